// File: doc/BRIEF.md
# Bidirectional Byte-Parity Transceiver Core

This block carries two bytes of data with one parity bit per byte in each of two directions between an A side and a B side. Each direction owns an 18-bit storage stage (16 data bits and 2 parity bits). A latch-enable input selects one of three behaviours. When it is high, the stage follows its inputs. When it is low, the stage loads its inputs on a rising edge of that direction's capture strobe. When it is low and no strobe edge arrives, the stage keeps its contents. The capture strobe is sampled on the core clock, and a rise is detected by comparing it with its value one cycle earlier.

The A-to-B direction can either generate a fresh parity bit for each byte or check the parity that arrives with each byte. The B-to-A direction only checks. A single odd/even select input applies to both directions. Each direction has one active-low error flag on its destination side, covering both bytes. Each flag is modelled as a drive-low enable, so several flags can be wire-ANDed. The bidirectional pins are split into an input, an output value and an output enable. Parity generation and checking work on the stored values, so flags and parity outputs follow the same timing as the data.

Top module: `bparity_xcvr`

## Requirements
- R1: While `rst` is high at a clock edge, both storage stages clear to zero. With `odd_sel` low, both error flags are then released (pull outputs low).
- R2: When a direction's latch enable is high, the stored data and parity take the input values at every clock edge. The new values appear on that direction's outputs after that edge.
- R3: When a direction's latch enable is low, the stage loads its inputs only at a clock edge where the capture strobe is sampled high and was sampled low at the previous edge. At all other edges it keeps its value.
- R4: When a direction's active-low output enable is high, that direction's data/parity drive enable is low and its error flag pull is low. Otherwise the drive enable is high.
- R5: In A-to-B generate mode (`ab_gen`=1) with `odd_sel`=0, `pb_out[i]` is the XOR of stored byte i, so each 9-bit group has an even count of ones. Byte i is data bits [8i+7:8i].
- R6: In A-to-B generate mode with `odd_sel`=1, `pb_out[i]` is the inverse of the XOR of stored byte i, so each 9-bit group has an odd count of ones.
- R7: In A-to-B check mode (`ab_gen`=0), byte i is in error when the ones count of the stored byte plus its stored parity bit is odd with `odd_sel`=0, or even with `odd_sel`=1. `b_err_pull` is high when either byte is in error and `ab_oe_n` is low.
- R8: In A-to-B check mode, `pb_out` equals the stored incoming parity bits, whatever the error state.
- R9: In A-to-B generate mode, `b_err_pull` stays low and the value on `pa_in` has no effect on any B-side output.
- R10: The B-to-A direction always checks with the same shared `odd_sel` rule. `pa_out` equals the stored `pb_in` bits, and `a_err_pull` is high when either stored byte is in error and `ba_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| odd_sel | input | 1 | Parity sense shared by both directions: 0 even, 1 odd |
| ab_gen | input | 1 | A-to-B parity mode: 1 generate, 0 check |
| ab_le | input | 1 | A-to-B latch enable (high = follow) |
| ab_stb | input | 1 | A-to-B capture strobe, rise detected on clk |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_le | input | 1 | B-to-A latch enable (high = follow) |
| ba_stb | input | 1 | B-to-A capture strobe, rise detected on clk |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| a_in | input | 16 | A-side data input |
| pa_in | input | 2 | A-side parity input, one bit per byte |
| a_out | output | 16 | A-side data output value |
| pa_out | output | 2 | A-side parity output value |
| a_oe | output | 1 | A-side data/parity drive enable |
| a_err_pull | output | 1 | A-side error flag: 1 pulls the shared line low |
| b_in | input | 16 | B-side data input |
| pb_in | input | 2 | B-side parity input |
| b_out | output | 16 | B-side data output value |
| pb_out | output | 2 | B-side parity output value |
| b_oe | output | 1 | B-side data/parity drive enable |
| b_err_pull | output | 1 | B-side error flag: 1 pulls the shared line low |

## Verification
The assertions assume that `rst` is high for at least one clock edge before any checking begins. They also assume that the capture strobes are level signals sampled on `clk`, never pulses narrower than a clock period. The stimulus changes every input one time unit after a falling edge, so every input holds steady across each rising edge. Strobes rise and fall across separate cycles. Data and parity words are drawn at random, and deliberate single-bit parity faults are injected into each byte in turn.

// File: rtl/tcv_pkg.sv
package tcv_pkg;

  typedef enum logic [1:0] {
    ST_KEEP   = 2'd0,
    ST_FOLLOW = 2'd1,
    ST_STROBE = 2'd2
  } store_mode_e;

  typedef enum logic {
    PM_CHECK = 1'b0,
    PM_GEN   = 1'b1
  } par_mode_e;

endpackage

// File: rtl/tcv_store.sv
module tcv_store #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic         stb,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  import tcv_pkg::*;

  logic        stb_q;
  logic        stb_rise;
  store_mode_e mode;

  assign stb_rise = stb & ~stb_q;

  always_comb begin
    if (le)            mode = ST_FOLLOW;
    else if (stb_rise) mode = ST_STROBE;
    else               mode = ST_KEEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q <= 1'b0;
      q     <= '0;
    end else begin
      stb_q <= stb;
      case (mode)
        ST_FOLLOW, ST_STROBE: q <= d;
        default:              q <= q;
      endcase
    end
  end

  // R1: storage is cleared by reset
  a_r1_clear: assert property (@(posedge clk) rst |=> q == '0);
  // R2: latch enable high makes the stage follow its input
  a_r2_follow: assert property (@(posedge clk) disable iff (rst)
    le |=> q == $past(d));
  // R3: with latch enable low and strobe not rising, contents are kept
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!le && !(stb && !stb_q)) |=> $stable(q));

endmodule

// File: rtl/tcv_parity.sv
module tcv_parity #(
  parameter int BYTES  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                    gen,
  input  logic                    odd_sel,
  input  logic [BYTES*BYTE_W-1:0] data,
  input  logic [BYTES-1:0]        par_in,
  output logic [BYTES-1:0]        par_out,
  output logic [BYTES-1:0]        err
);
  import tcv_pkg::*;

  par_mode_e pm;
  assign pm = par_mode_e'(gen);

  for (genvar g = 0; g < BYTES; g++) begin : g_byte
    logic [BYTE_W-1:0] bits;
    logic              red;
    assign bits       = data[g*BYTE_W +: BYTE_W];
    assign red        = ^bits;
    assign par_out[g] = (pm == PM_GEN) ? (red ^ odd_sel) : par_in[g];
    assign err[g]     = (pm == PM_CHECK) & (red ^ par_in[g] ^ odd_sel);
  end

endmodule

// File: rtl/bparity_xcvr.sv
module bparity_xcvr #(
  parameter int BYTES  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    odd_sel,
  input  logic                    ab_gen,
  input  logic                    ab_le,
  input  logic                    ab_stb,
  input  logic                    ab_oe_n,
  input  logic                    ba_le,
  input  logic                    ba_stb,
  input  logic                    ba_oe_n,
  input  logic [BYTES*BYTE_W-1:0] a_in,
  input  logic [BYTES-1:0]        pa_in,
  output logic [BYTES*BYTE_W-1:0] a_out,
  output logic [BYTES-1:0]        pa_out,
  output logic                    a_oe,
  output logic                    a_err_pull,
  input  logic [BYTES*BYTE_W-1:0] b_in,
  input  logic [BYTES-1:0]        pb_in,
  output logic [BYTES*BYTE_W-1:0] b_out,
  output logic [BYTES-1:0]        pb_out,
  output logic                    b_oe,
  output logic                    b_err_pull
);
  localparam int DW = BYTES * BYTE_W;
  localparam int SW = DW + BYTES;

  logic [SW-1:0]    ab_q, ba_q;
  logic [BYTES-1:0] ab_err, ba_err;
  logic [BYTES-1:0] ba_par_unused;

  tcv_store #(.W(SW)) u_ab_store (
    .clk (clk), .rst (rst), .le (ab_le), .stb (ab_stb),
    .d   ({pa_in, a_in}), .q (ab_q)
  );

  tcv_store #(.W(SW)) u_ba_store (
    .clk (clk), .rst (rst), .le (ba_le), .stb (ba_stb),
    .d   ({pb_in, b_in}), .q (ba_q)
  );

  tcv_parity #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_ab_par (
    .gen (ab_gen), .odd_sel (odd_sel), .data (ab_q[DW-1:0]),
    .par_in (ab_q[SW-1:DW]), .par_out (pb_out), .err (ab_err)
  );

  tcv_parity #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_ba_par (
    .gen (1'b0), .odd_sel (odd_sel), .data (ba_q[DW-1:0]),
    .par_in (ba_q[SW-1:DW]), .par_out (ba_par_unused), .err (ba_err)
  );

  assign b_out      = ab_q[DW-1:0];
  assign b_oe       = ~ab_oe_n;
  assign b_err_pull = ~ab_oe_n & (|ab_err);

  assign a_out      = ba_q[DW-1:0];
  assign pa_out     = ba_q[SW-1:DW];
  assign a_oe       = ~ba_oe_n;
  assign a_err_pull = ~ba_oe_n & (|ba_err);

  // R4: a disabled direction neither drives nor flags
  a_r4_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    ab_oe_n |-> (!b_oe && !b_err_pull));
  // R8: check mode passes the stored parity through
  a_r8_pass_parity: assert property (@(posedge clk) disable iff (rst)
    !ab_gen |-> pb_out == ab_q[SW-1:DW]);
  // R9: generate mode never raises the B-side flag
  a_r9_gen_no_flag: assert property (@(posedge clk) disable iff (rst)
    ab_gen |-> !b_err_pull);
  // R10: B-to-A parity output equals the stored parity bits
  a_r10_ba_pass: assert property (@(posedge clk) disable iff (rst)
    pa_out == ba_par_unused);

  for (genvar g = 0; g < BYTES; g++) begin : g_chk
    // R5/R6: each generated 9-bit group has the selected ones-count sense
    a_r5_r6_gen_sense: assert property (@(posedge clk) disable iff (rst)
      ab_gen |-> ((^{b_out[g*BYTE_W +: BYTE_W], pb_out[g]}) == odd_sel));
  end

endmodule

// File: tb/bparity_xcvr_bench.sv
module bparity_xcvr_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        odd_sel = 1'b0, ab_gen = 1'b0;
  logic        ab_le = 1'b0, ab_stb = 1'b0, ab_oe_n = 1'b0;
  logic        ba_le = 1'b0, ba_stb = 1'b0, ba_oe_n = 1'b0;
  logic [15:0] a_in = '0, b_in = '0;
  logic [1:0]  pa_in = '0, pb_in = '0;
  logic [15:0] a_out, b_out;
  logic [1:0]  pa_out, pb_out;
  logic        a_oe, b_oe, a_err_pull, b_err_pull;

  int checks = 0, fails = 0;
  bit started = 0;

  bparity_xcvr u_bparity_xcvr (
    .clk(clk), .rst(rst), .odd_sel(odd_sel), .ab_gen(ab_gen),
    .ab_le(ab_le), .ab_stb(ab_stb), .ab_oe_n(ab_oe_n),
    .ba_le(ba_le), .ba_stb(ba_stb), .ba_oe_n(ba_oe_n),
    .a_in(a_in), .pa_in(pa_in), .a_out(a_out), .pa_out(pa_out),
    .a_oe(a_oe), .a_err_pull(a_err_pull),
    .b_in(b_in), .pb_in(pb_in), .b_out(b_out), .pb_out(pb_out),
    .b_oe(b_oe), .b_err_pull(b_err_pull)
  );

  always #2 clk = ~clk;

  // behavioural reference: stored words and previous strobe samples
  logic [17:0] m_ab = '0, m_ba = '0;
  bit prev_ab = 0, prev_ba = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_ab = '0; m_ba = '0; prev_ab = 0; prev_ba = 0;
    end else begin
      if (ab_le || (ab_stb && !prev_ab)) m_ab = {pa_in, a_in};
      if (ba_le || (ba_stb && !prev_ba)) m_ba = {pb_in, b_in};
      prev_ab = ab_stb; prev_ba = ba_stb;
    end
    started = 1;
  end

  function automatic bit gen_bit(logic [7:0] by, bit sel);
    int ones = $countones(by);
    return (sel == 0) ? bit'(ones % 2) : bit'(1 - ones % 2);
  endfunction

  function automatic bit bad_byte(logic [7:0] by, bit p, bit sel);
    int sum = $countones(by) + int'(p);
    return (sum % 2) != int'(sel);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      string dt, pt, ft;
      logic [1:0] e_pb;
      bit ab_bad, ba_bad;
      dt = rst ? "R1" : (ab_le ? "R2" : "R3");
      chk({dt, " b_out"}, b_out, m_ab[15:0]);
      for (int i = 0; i < 2; i++)
        e_pb[i] = ab_gen ? gen_bit(m_ab[8*i +: 8], odd_sel) : m_ab[16+i];
      pt = ab_gen ? (odd_sel ? "R6" : "R5") : "R8";
      chk({pt, " pb_out"}, pb_out, e_pb);
      chk("R4 b_oe", b_oe, !ab_oe_n);
      ab_bad = !ab_gen && (bad_byte(m_ab[7:0], m_ab[16], odd_sel) ||
                           bad_byte(m_ab[15:8], m_ab[17], odd_sel));
      ft = rst ? "R1" : (ab_oe_n ? "R4" : (ab_gen ? "R9" : "R7"));
      chk({ft, " b_err_pull"}, b_err_pull, ab_bad && !ab_oe_n);

      dt = rst ? "R1" : (ba_le ? "R2" : "R3");
      chk({dt, " a_out"}, a_out, m_ba[15:0]);
      chk("R10 pa_out", pa_out, m_ba[17:16]);
      chk("R4 a_oe", a_oe, !ba_oe_n);
      ba_bad = bad_byte(m_ba[7:0], m_ba[16], odd_sel) ||
               bad_byte(m_ba[15:8], m_ba[17], odd_sel);
      ft = rst ? "R1" : (ba_oe_n ? "R4" : "R10");
      chk({ft, " a_err_pull"}, a_err_pull, ba_bad && !ba_oe_n);
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0; ab_le = 1'b1; ba_le = 1'b1;
    // R2 with R7/R8/R10: check mode, random words, both senses
    for (int k = 0; k < 40; k++) begin
      odd_sel = k[0];
      a_in = 16'($urandom); pa_in = 2'($urandom);
      b_in = 16'($urandom); pb_in = 2'($urandom);
      tick(1);
    end
    // R7: correct parity, then a fault on one byte at a time
    for (int k = 0; k < 12; k++) begin
      odd_sel = k[1];
      a_in = 16'($urandom); b_in = 16'($urandom);
      pa_in[0] = gen_bit(a_in[7:0], odd_sel) ^ (k % 3 == 1);
      pa_in[1] = gen_bit(a_in[15:8], odd_sel) ^ (k % 3 == 2);
      pb_in[0] = gen_bit(b_in[7:0], odd_sel) ^ (k % 3 == 2);
      pb_in[1] = gen_bit(b_in[15:8], odd_sel) ^ (k % 3 == 1);
      tick(1);
    end
    // R5/R6/R9: generate mode with arbitrary pa_in
    ab_gen = 1'b1;
    for (int k = 0; k < 40; k++) begin
      odd_sel = k[2];
      a_in = 16'($urandom); pa_in = 2'($urandom);
      tick(1);
    end
    // R9: only pa_in changes in generate mode
    a_in = 16'h00ff;
    for (int k = 0; k < 4; k++) begin pa_in = 2'(k); tick(1); end
    // R3: strobe capture and hold
    ab_gen = 1'b0; ab_le = 1'b0; ba_le = 1'b0;
    for (int k = 0; k < 30; k++) begin
      a_in = 16'($urandom); pa_in = 2'($urandom);
      b_in = 16'($urandom); pb_in = 2'($urandom);
      ab_stb = (k % 3 == 0); ba_stb = (k % 4 == 1);
      tick(1);
    end
    ab_stb = 1'b1; ba_stb = 1'b1; tick(1);
    for (int k = 0; k < 6; k++) begin
      a_in = 16'($urandom); b_in = 16'($urandom); tick(1);
    end
    // R4: disable each direction with errors present
    ab_stb = 1'b0; ba_stb = 1'b0; ab_le = 1'b1; ba_le = 1'b1;
    a_in = 16'h0001; pa_in = 2'b00; b_in = 16'h0100; pb_in = 2'b00;
    odd_sel = 1'b0;
    tick(2);
    ab_oe_n = 1'b1; tick(2);
    ba_oe_n = 1'b1; tick(2);
    ab_oe_n = 1'b0; ba_oe_n = 1'b0; tick(2);
    // R1: reset again clears storage
    odd_sel = 1'b0; rst = 1'b1; tick(2);
    rst = 1'b0; ab_le = 1'b0; ba_le = 1'b0; tick(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule